// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block takes a parameterised set of external level interrupt sources and steers each one to a single interrupt line of a single processor. Software programs the routing through a small byte-addressed register window. Each source has an enable bit, a captured pending bit, a pin selector and a processor selector. For every processor and every pin, the line driven to that processor is the OR of all sources that are routed there, enabled and pending.

Software controls enables through separate set and clear windows, so no read-modify-write is needed. The processor selector is written as a one-hot word. A software force register can raise or drop the pending state of any source. Accesses to the bit-packed windows may be 1, 2, 4 or 8 bytes wide. An access that would reach past the last source returns zero and changes nothing.

Top module: `irq_router`

## Requirements
- R1: A change of a source input level is stored as that source's pending bit whether or not the source is enabled. Enabling a pending, routed source then raises its line.
- R2: Line `p*(NUM_PIN+2) + k + 2` of `cpu_irq` is the OR of pending over every source that is enabled, has pin field k and targets processor p. Lines 0 and 1 of each processor group stay low.
- R3: `cpu_irq` is registered. It changes at the clock edge that samples the input change or the register write causing it, and not before.
- R4: The pending window (0x000–0x01F, read) and the enable window (0x020–0x03F, read) hold source `8*offset + bit`. `reg_size` selects the access width: 0 for 1 byte, 1 for 2, 2 for 4, 3 for 8. A read whose bit range passes the last source returns 0.
- R5: A 1 bit written to the set window (0x040–0x05F) enables that source. A 1 bit written to the clear window (0x060–0x07F) disables it. Zero bits leave sources unchanged. A write reaching past the last source has no effect.
- R6: The pin selector of source n is at 0x400 + 4n. It holds a route flag in bit 31 and a pin in bits [5:0]. A write with a pin above NUM_PIN-1 is ignored. A read returns the stored flag and pin.
- R7: The processor selector of source n is at 0x2000 + 32n. Writing 0 unmaps the source. A nonzero write selects the lowest set bit, and is ignored if that bit is not below NUM_PROC. A read returns a one-hot word, or 0 when the source is unmapped.
- R8: A write to the force register at 0x080 sets the pending bit of source `wdata[30:0]` to `wdata[31]`. An index of NUM_SRC or more is ignored.
- R9: When a force write and an input level change hit the same source in the same cycle, the force write decides the pending bit.
- R10: After reset, all enables and pending bits are 0, every pin selector reads 0x8000_0000, every processor selector reads 0, and `cpu_irq` is 0.
- R11: A pin or processor selector address for a source index of NUM_SRC or more reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | External source levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 14 | Byte offset of the access |
| reg_size | input | 2 | Access width code: 0 for 1 byte, 1 for 2, 2 for 4, 3 for 8 |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`/`reg_size`, combinational |
| cpu_irq | output | NUM_PROC*(NUM_PIN+2) | Per-processor interrupt lines |

## Verification
The pending bit of a source has two writers: the edge capture of its input level and the software force register. Both can land on the same source in one clock. The bench provokes this by toggling an input line in the same cycle as a force write of the opposite value to that source, in both directions. It then reads the pending window and expects the force value. A further idle cycle confirms that the already-seen input level does not overwrite that result.

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PROC = 2,
  parameter int NUM_PIN  = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SRC-1:0]                src_in,
  input  logic                              reg_wr,
  input  logic [13:0]                       reg_addr,
  input  logic [1:0]                        reg_size,
  input  logic [63:0]                       reg_wdata,
  output logic [63:0]                       reg_rdata,
  output logic [NUM_PROC*(NUM_PIN+2)-1:0]   cpu_irq
);
  localparam int         LINES    = NUM_PIN + 2;
  localparam int         IW       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int         PW       = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1;
  localparam logic [5:0] MAX_PIN  = 6'(NUM_PIN - 1);
  localparam logic [8:0] SRC_LIM  = 9'(NUM_SRC);
  localparam logic [6:0] PROC_LIM = 7'(NUM_PROC);

  logic [NUM_SRC-1:0] en_q, pend_q, src_q, flag_q, tv_q;
  logic [5:0]         pin_q [NUM_SRC];
  logic [PW-1:0]      ti_q  [NUM_SRC];
  logic [NUM_SRC-1:0] en_d, pend_d, flag_d, tv_d;
  logic [5:0]         pin_d [NUM_SRC];
  logic [PW-1:0]      ti_d  [NUM_SRC];
  logic [NUM_PROC*LINES-1:0] irq_q, irq_d;

  wire [8:0] grp       = reg_addr[13:5];
  wire       hit_pend  = grp == 9'd0;
  wire       hit_mask  = grp == 9'd1;
  wire       hit_set   = grp == 9'd2;
  wire       hit_clr   = grp == 9'd3;
  wire       hit_wedge = reg_addr == 14'h080;
  wire       pin_ok    = (reg_addr[13:10] == 4'b0001) && ({1'b0, reg_addr[9:2]} < SRC_LIM);
  wire       tgt_ok    = reg_addr[13] && ({1'b0, reg_addr[12:5]} < SRC_LIM);
  wire [IW-1:0] pin_i  = reg_addr[IW+1:2];
  wire [IW-1:0] tgt_i  = reg_addr[IW+4:5];

  wire [7:0]  bit_base  = {reg_addr[4:0], 3'b000};
  wire [9:0]  nbits     = 10'd8 << reg_size;
  wire        span_ok   = ({2'b00, bit_base} + nbits) <= {1'b0, SRC_LIM};
  wire [63:0] lane_mask = (reg_size == 2'd3) ? '1 : ((64'd1 << nbits) - 64'd1);
  wire [NUM_SRC+63:0] wr_wide = {{NUM_SRC{1'b0}}, reg_wdata & lane_mask} << bit_base;
  wire [NUM_SRC-1:0]  wr_bits = span_ok ? wr_wide[NUM_SRC-1:0] : '0;

  wire          wedge_ok = hit_wedge && (reg_wdata[30:8] == '0) && ({1'b0, reg_wdata[7:0]} < SRC_LIM);
  wire [IW-1:0] wedge_i  = reg_wdata[IW-1:0];
  wire          pin_legal = reg_wdata[5:0] <= MAX_PIN;

  logic [5:0] low_bit;
  always_comb begin
    low_bit = '0;
    for (int b = 63; b >= 0; b--)
      if (reg_wdata[b]) low_bit = 6'(b);
  end
  wire any_bit   = |reg_wdata;
  wire tgt_legal = !any_bit || ({1'b0, low_bit} < PROC_LIM);

  always_comb begin
    logic [NUM_SRC-1:0] chg;
    chg    = src_in ^ src_q;
    pend_d = (pend_q & ~chg) | (src_in & chg);
    if (reg_wr && wedge_ok) pend_d[wedge_i] = reg_wdata[31];
    en_d = en_q;
    if (reg_wr && hit_set) en_d = en_q | wr_bits;
    if (reg_wr && hit_clr) en_d = en_q & ~wr_bits;
    flag_d = flag_q;
    tv_d   = tv_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      pin_d[s] = pin_q[s];
      ti_d[s]  = ti_q[s];
      if (reg_wr && pin_ok && pin_legal && pin_i == IW'(s)) begin
        flag_d[s] = reg_wdata[31];
        pin_d[s]  = reg_wdata[5:0];
      end
      if (reg_wr && tgt_ok && tgt_legal && tgt_i == IW'(s)) begin
        tv_d[s] = any_bit;
        ti_d[s] = low_bit[PW-1:0];
      end
    end
  end

  always_comb begin
    irq_d = '0;
    for (int s = 0; s < NUM_SRC; s++)
      for (int p = 0; p < NUM_PROC; p++)
        for (int k = 0; k < NUM_PIN; k++)
          if (en_d[s] && pend_d[s] && tv_d[s] && ti_d[s] == PW'(p) && pin_d[s] == 6'(k))
            irq_d[p*LINES + k + 2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      src_q  <= '0;
      flag_q <= '1;
      tv_q   <= '0;
      irq_q  <= '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        pin_q[s] <= '0;
        ti_q[s]  <= '0;
      end
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      src_q  <= src_in;
      flag_q <= flag_d;
      tv_q   <= tv_d;
      irq_q  <= irq_d;
      for (int s = 0; s < NUM_SRC; s++) begin
        pin_q[s] <= pin_d[s];
        ti_q[s]  <= ti_d[s];
      end
    end
  end

  assign cpu_irq = irq_q;

  always_comb begin
    logic [NUM_SRC+63:0] rd_wide;
    rd_wide   = {64'd0, (hit_mask ? en_q : pend_q)} >> bit_base;
    reg_rdata = '0;
    if ((hit_pend || hit_mask) && span_ok)
      reg_rdata = rd_wide[63:0] & lane_mask;
    else if (pin_ok)
      reg_rdata = {32'd0, flag_q[pin_i], 25'd0, pin_q[pin_i]};
    else if (tgt_ok && tv_q[tgt_i])
      reg_rdata = 64'd1 << ti_q[tgt_i];
  end

  a_r2_line_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_irq) |-> (|(en_q & pend_q & tv_q)));

  a_r8_wedge_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wedge_ok) |=> (pend_q[$past(wedge_i)] == $past(reg_wdata[31])));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    a_r6_pin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      pin_q[s] <= MAX_PIN);
    a_r7_target_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      tv_q[s] |-> ({{(7-PW){1'b0}}, ti_q[s]} < PROC_LIM));
  end
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        reg_wr = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [1:0]  reg_size = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [15:0] cpu_irq;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [13:0] a, input logic [1:0] sz, input logic [63:0] exp);
    reg_addr = a; reg_size = sz;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; src_in = '0; reg_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset;
    rdchk("R10 pending", 14'h000, 2'd2, 64'h0);
    rdchk("R10 enables", 14'h020, 2'd2, 64'h0);
    rdchk("R10 pin map", 14'h41C, 2'd2, 64'h8000_0000);
    rdchk("R10 proc map", 14'h2000, 2'd2, 64'h0);
    chk("R10 lines", 64'(cpu_irq), 64'h0);
  endtask

  task automatic t_route;
    do_reset;
    wr(14'h40C, 2'd2, 64'd2);
    wr(14'h2060, 2'd2, 64'd2);
    wr(14'h040, 2'd0, 64'h08);
    chk("R2 idle", 64'(cpu_irq), 64'h0);
    @(negedge clk); src_in[3] = 1'b1;
    #1 chk("R3 before edge", 64'(cpu_irq), 64'h0);
    @(negedge clk);
    chk("R3 after edge", 64'(cpu_irq), 64'h1000);
    wr(14'h414, 2'd2, 64'd2);
    wr(14'h20A0, 2'd2, 64'd2);
    wr(14'h040, 2'd0, 64'h20);
    @(negedge clk); src_in[5] = 1'b1;
    @(negedge clk); src_in[3] = 1'b0;
    @(negedge clk);
    chk("R2 shared pin OR", 64'(cpu_irq), 64'h1000);
    src_in[5] = 1'b0;
    @(negedge clk);
    chk("R2 all dropped", 64'(cpu_irq), 64'h0);
    wr(14'h40C, 2'd2, 64'd5);
    wr(14'h2060, 2'd2, 64'd1);
    src_in[3] = 1'b1;
    @(negedge clk);
    chk("R2 proc0 pin5", 64'(cpu_irq), 64'h0080);
    wr(14'h060, 2'd0, 64'h08);
    chk("R3 clear write", 64'(cpu_irq), 64'h0);
  endtask

  task automatic t_disabled;
    do_reset;
    src_in[7] = 1'b1;
    @(negedge clk);
    rdchk("R1 pending while disabled", 14'h000, 2'd0, 64'h80);
    wr(14'h41C, 2'd2, 64'd0);
    wr(14'h20E0, 2'd2, 64'd1);
    chk("R1 still off", 64'(cpu_irq), 64'h0);
    wr(14'h040, 2'd0, 64'h80);
    chk("R1 enable raises", 64'(cpu_irq), 64'h0004);
  endtask

  task automatic t_mask;
    do_reset;
    wr(14'h040, 2'd0, 64'hA5);
    rdchk("R5 set", 14'h020, 2'd0, 64'hA5);
    wr(14'h040, 2'd0, 64'h02);
    rdchk("R5 zeros keep", 14'h020, 2'd0, 64'hA7);
    wr(14'h060, 2'd0, 64'h21);
    rdchk("R5 clear", 14'h020, 2'd0, 64'h86);
    wr(14'h041, 2'd0, 64'hFF);
    rdchk("R5 byte offset", 14'h020, 2'd2, 64'h0000_FF86);
    wr(14'h043, 2'd1, 64'hFFFF);
    rdchk("R5 overrun write", 14'h020, 2'd2, 64'h0000_FF86);
  endtask

  task automatic t_window;
    do_reset;
    src_in[9] = 1'b1; src_in[31] = 1'b1;
    @(negedge clk);
    rdchk("R4 byte 1", 14'h001, 2'd0, 64'h02);
    rdchk("R4 half at 2", 14'h002, 2'd1, 64'h8000);
    rdchk("R4 word", 14'h000, 2'd2, 64'h8000_0200);
    rdchk("R4 overrun half", 14'h003, 2'd1, 64'h0);
    rdchk("R4 overrun dword", 14'h000, 2'd3, 64'h0);
  endtask

  task automatic t_maps;
    do_reset;
    wr(14'h404, 2'd2, 64'd6);
    rdchk("R6 illegal pin", 14'h404, 2'd2, 64'h8000_0000);
    wr(14'h404, 2'd2, 64'd5);
    rdchk("R6 pin 5", 14'h404, 2'd2, 64'h5);
    wr(14'h404, 2'd2, 64'h8000_0003);
    rdchk("R6 flag+pin", 14'h404, 2'd2, 64'h8000_0003);
    wr(14'h2020, 2'd2, 64'hC);
    rdchk("R7 bit too high", 14'h2020, 2'd2, 64'h0);
    wr(14'h2020, 2'd2, 64'h6);
    rdchk("R7 lowest bit", 14'h2020, 2'd2, 64'h2);
    wr(14'h040, 2'd0, 64'h02);
    src_in[1] = 1'b1;
    @(negedge clk);
    chk("R7 routed", 64'(cpu_irq), 64'h2000);
    wr(14'h2020, 2'd2, 64'h0);
    rdchk("R7 unmapped read", 14'h2020, 2'd2, 64'h0);
    chk("R7 unmapped line", 64'(cpu_irq), 64'h0);
    wr(14'h2020, 2'd3, 64'h8000_0000_0000_0001);
    rdchk("R7 dword", 14'h2020, 2'd2, 64'h1);
    wr(14'h480, 2'd2, 64'd3);
    rdchk("R11 pin map past end", 14'h480, 2'd2, 64'h0);
    wr(14'h2400, 2'd2, 64'd1);
    rdchk("R11 proc map past end", 14'h2400, 2'd2, 64'h0);
  endtask

  task automatic t_wedge;
    do_reset;
    wr(14'h080, 2'd2, 64'h8000_0004);
    rdchk("R8 force set", 14'h000, 2'd0, 64'h10);
    wr(14'h410, 2'd2, 64'd1);
    wr(14'h2080, 2'd2, 64'd1);
    wr(14'h040, 2'd0, 64'h10);
    chk("R8 forced line", 64'(cpu_irq), 64'h0008);
    wr(14'h080, 2'd2, 64'h4);
    rdchk("R8 force clear", 14'h000, 2'd0, 64'h0);
    chk("R8 line drops", 64'(cpu_irq), 64'h0);
    wr(14'h080, 2'd2, 64'h8000_0020);
    rdchk("R8 index past end", 14'h000, 2'd2, 64'h0);
  endtask

  task automatic t_collide;
    do_reset;
    @(negedge clk);
    src_in[6] = 1'b1;
    reg_wr = 1'b1; reg_addr = 14'h080; reg_size = 2'd2; reg_wdata = 64'h6;
    @(negedge clk);
    reg_wr = 1'b0;
    rdchk("R9 clear beats rise", 14'h000, 2'd0, 64'h0);
    src_in[6] = 1'b0;
    reg_wr = 1'b1; reg_addr = 14'h080; reg_size = 2'd2; reg_wdata = 64'h8000_0006;
    @(negedge clk);
    reg_wr = 1'b0;
    rdchk("R9 set beats fall", 14'h000, 2'd0, 64'h40);
    @(negedge clk);
    rdchk("R9 holds", 14'h000, 2'd0, 64'h40);
  endtask

  initial begin
    t_reset;
    t_route;
    t_disabled;
    t_mask;
    t_window;
    t_maps;
    t_wedge;
    t_collide;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule